// File: doc/BRIEF.md
# Inversion-retry ECC write controller

This controller sits between a host and a memory array whose worn cells can be permanently stuck at 0 or at 1. Each data word is protected by a single-error-correcting Hamming code. After every write the controller reads the stored word back and counts the cells that disagree with what was intended. If more cells are wrong than the code can correct, it writes the word once more in inverted form and records the inversion in a polarity bit. A stuck cell that was wrong for the first pattern is then right for the second. Reads decode the word and undo any inversion, so the host always sees the original value.

A parameter selects one of two ways to handle the polarity bit. In integrated mode the polarity bit is part of the payload covered by the code, and the check bits are recomputed on retry. In unintegrated mode the polarity bit is stored in three copies outside the codeword, and the whole codeword, check bits included, is inverted on retry. On read the three copies are resolved by majority vote before decoding.

Top module: `inv_retry_ecc_ctrl`

## Requirements
- R1: Stored word layout, by bit index of the array word. Data bit i (i = 0..7) sits at index 2, 4, 5, 6, 8, 9, 10, 11 in that order, and check bits sit at indices 0, 1, 3 and 7. In integrated mode the polarity bit is index 12, which gives a 13-bit word. In unintegrated mode indices 12..14 hold the three polarity copies, which gives a 15-bit word.
- R2: The first attempt of every write uses polarity 0. The word is then read back, and if at most one codeword bit differs from the intended value, the request completes after exactly one array write with `wr_done_err` = 0.
- R3: If the first attempt fails verification, a second write follows, with the data inverted and polarity 1. In integrated mode the check bits are recomputed over the inverted data plus polarity. In unintegrated mode the first codeword is inverted bit for bit and all three copies are set to 1. If this second attempt verifies, the request completes with `wr_done_err` = 0.
- R4: If the inverted attempt also fails, no further write is made. The request completes with `wr_done_err` = 1, and `block_defective` goes to 1 and stays at 1 until reset.
- R5: Reading an address whose last write completed without error returns the original data. `rd_resp_corrected` is 1 exactly when one stored codeword bit was wrong.
- R6: In unintegrated mode, a single corrupted polarity copy does not change the data returned by a read.
- R7: Requests are accepted only while the controller is idle. When `wr_valid` and `rd_valid` are both high, the write is taken and `rd_ready` is held low.
- R8: After reset `wr_ready` is 1, and `block_defective`, `wr_done_valid` and `rd_resp_valid` are 0.
- R9: A write request never causes more than two array writes, and the array never sees a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with wr_valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_done_valid | output | 1 | One-cycle pulse when a write request completes |
| wr_done_err | output | 1 | With wr_done_valid: both attempts failed |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_addr | input | ADDR_W | Read address |
| rd_resp_valid | output | 1 | One-cycle pulse carrying read data |
| rd_resp_data | output | DATA_W | Decoded, polarity-corrected data |
| rd_resp_corrected | output | 1 | Decoder corrected one bit |
| block_defective | output | 1 | Sticky: an inverted retry failed |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe, data returned next cycle |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | ARR_W | Array write word (13 or 15 bits) |
| arr_rdata | input | ARR_W | Array read word, valid one cycle after arr_re |

## Verification
The hardest case to reach is a write that fails the first attempt but passes the inverted one, with the decoder still left to correct one bit. It needs stuck cells whose values agree with some data bits and disagree with others, in a known proportion. The bench's array model applies per-address stuck-at masks placed only on data-bit positions. The bench derives the wrong-cell count of each attempt from the data and the mask, so it knows in advance how many writes, which error flag and which correction flag to expect. The same stimulus drives an integrated and an unintegrated instance side by side, and an extra fault on one polarity copy exercises the majority vote.

// File: rtl/invr_pkg.sv
package invr_pkg;

    localparam int T_CORR   = 1;
    localparam int POL_COPY = 3;

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // smallest r with 2^r >= k + r + 1
    function automatic int check_bits(input int k);
        int r;
        r = 1;
        while ((1 << r) < (k + r + 1)) r++;
        return r;
    endfunction

    // one-based codeword position of payload bit k
    function automatic int data_pos(input int k);
        int cnt;
        cnt = 0;
        for (int p = 1; p < 256; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == k) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    function automatic logic vote3(input logic [2:0] c);
        return (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_VREQ,
        ST_VCHK,
        ST_RREQ,
        ST_RRET
    } ctrl_state_e;

endpackage

// File: rtl/invr_hamming_enc.sv
module invr_hamming_enc #(
    parameter int K = 8,
    localparam int R = invr_pkg::check_bits(K),
    localparam int N = K + R
) (
    input  logic [K-1:0] d,
    output logic [N-1:0] cw
);
    import invr_pkg::*;

    always_comb begin
        logic par;
        cw = '0;
        for (int k = 0; k < K; k++) cw[data_pos(k) - 1] = d[k];
        for (int r = 0; r < R; r++) begin
            par = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if ((((p >> r) & 1) == 1) && !is_pow2(p)) par = par ^ cw[p - 1];
            end
            cw[(1 << r) - 1] = par;
        end
    end
endmodule

// File: rtl/invr_hamming_dec.sv
module invr_hamming_dec #(
    parameter int K = 8,
    localparam int R = invr_pkg::check_bits(K),
    localparam int N = K + R
) (
    input  logic [N-1:0] cw,
    output logic [K-1:0] d,
    output logic         corrected
);
    import invr_pkg::*;

    logic [R-1:0] syn;
    logic [N-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= N; p++) begin
            if (cw[p - 1]) syn = syn ^ R'(p);
        end
        fixed = cw;
        if ((syn != '0) && (int'(syn) <= N)) fixed[int'(syn) - 1] = ~cw[int'(syn) - 1];
        for (int k = 0; k < K; k++) d[k] = fixed[data_pos(k) - 1];
        corrected = (syn != '0);
    end
endmodule

// File: rtl/invr_mismatch.sv
module invr_mismatch #(
    parameter int W = 13,
    parameter int T = 1
) (
    input  logic [W-1:0] got,
    input  logic [W-1:0] want,
    output logic         ok
);
    logic [W-1:0] diff;
    int           cnt;

    always_comb begin
        diff = got ^ want;
        cnt  = 0;
        for (int i = 0; i < W; i++) cnt = cnt + int'(diff[i]);
        ok = (cnt <= T);
    end
endmodule

// File: rtl/inv_retry_ecc_ctrl.sv
module inv_retry_ecc_ctrl #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter bit INTEGRATED = 1'b1,
    localparam int K_PAY = DATA_W + int'(INTEGRATED),
    localparam int CW_W  = K_PAY + invr_pkg::check_bits(K_PAY),
    localparam int ARR_W = INTEGRATED ? CW_W : CW_W + invr_pkg::POL_COPY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_done_valid,
    output logic              wr_done_err,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              rd_resp_corrected,
    output logic              block_defective,
    output logic              arr_we,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [ARR_W-1:0]  arr_wdata,
    input  logic [ARR_W-1:0]  arr_rdata
);
    import invr_pkg::*;

    ctrl_state_e       state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              retry_q;
    logic [ARR_W-1:0]  wr_word;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              verify_ok;

    generate
        if (INTEGRATED) begin : g_integrated
            logic [K_PAY-1:0] pay_w;
            logic [K_PAY-1:0] pay_r;
            logic [CW_W-1:0]  cw_w;

            assign pay_w = {retry_q, (retry_q ? ~data_q : data_q)};

            invr_hamming_enc #(.K(K_PAY)) u_enc (.d(pay_w), .cw(cw_w));
            assign wr_word = cw_w;

            invr_hamming_dec #(.K(K_PAY)) u_dec (
                .cw(arr_rdata[CW_W-1:0]), .d(pay_r), .corrected(dec_corr)
            );
            assign dec_data = pay_r[K_PAY-1] ? ~pay_r[DATA_W-1:0] : pay_r[DATA_W-1:0];
        end else begin : g_unintegrated
            logic [CW_W-1:0]   cw_w;
            logic [CW_W-1:0]   cw_r;
            logic              pol_r;

            invr_hamming_enc #(.K(K_PAY)) u_enc (.d(data_q), .cw(cw_w));
            assign wr_word = retry_q ? {{POL_COPY{1'b1}}, ~cw_w} : {{POL_COPY{1'b0}}, cw_w};

            assign pol_r = vote3(arr_rdata[ARR_W-1 -: POL_COPY]);
            assign cw_r  = pol_r ? ~arr_rdata[CW_W-1:0] : arr_rdata[CW_W-1:0];

            invr_hamming_dec #(.K(K_PAY)) u_dec (
                .cw(cw_r), .d(dec_data), .corrected(dec_corr)
            );
        end
    endgenerate

    invr_mismatch #(.W(CW_W), .T(T_CORR)) u_cmp (
        .got(arr_rdata[CW_W-1:0]), .want(wr_word[CW_W-1:0]), .ok(verify_ok)
    );

    assign wr_ready  = (state == ST_IDLE);
    assign rd_ready  = (state == ST_IDLE) && !wr_valid;
    assign arr_we    = (state == ST_WRITE);
    assign arr_re    = (state == ST_VREQ) || (state == ST_RREQ);
    assign arr_addr  = addr_q;
    assign arr_wdata = wr_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state             <= ST_IDLE;
            addr_q            <= '0;
            data_q            <= '0;
            retry_q           <= 1'b0;
            wr_done_valid     <= 1'b0;
            wr_done_err       <= 1'b0;
            rd_resp_valid     <= 1'b0;
            rd_resp_data      <= '0;
            rd_resp_corrected <= 1'b0;
            block_defective   <= 1'b0;
        end else begin
            wr_done_valid <= 1'b0;
            rd_resp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (wr_valid) begin
                        addr_q  <= wr_addr;
                        data_q  <= wr_data;
                        retry_q <= 1'b0;
                        state   <= ST_WRITE;
                    end else if (rd_valid) begin
                        addr_q <= rd_addr;
                        state  <= ST_RREQ;
                    end
                end
                ST_WRITE: state <= ST_VREQ;
                ST_VREQ:  state <= ST_VCHK;
                ST_VCHK: begin
                    if (verify_ok) begin
                        wr_done_valid <= 1'b1;
                        wr_done_err   <= 1'b0;
                        state         <= ST_IDLE;
                    end else if (!retry_q) begin
                        retry_q <= 1'b1;
                        state   <= ST_WRITE;
                    end else begin
                        wr_done_valid   <= 1'b1;
                        wr_done_err     <= 1'b1;
                        block_defective <= 1'b1;
                        state           <= ST_IDLE;
                    end
                end
                ST_RREQ: state <= ST_RRET;
                ST_RRET: begin
                    rd_resp_valid     <= 1'b1;
                    rd_resp_data      <= dec_data;
                    rd_resp_corrected <= dec_corr;
                    state             <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/invr_checker.sv
module invr_checker #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter bit INTEGRATED = 1'b1,
    localparam int K_PAY = DATA_W + int'(INTEGRATED),
    localparam int CW_W  = K_PAY + invr_pkg::check_bits(K_PAY),
    localparam int ARR_W = INTEGRATED ? CW_W : CW_W + invr_pkg::POL_COPY
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_ready,
    input logic             wr_done_valid,
    input logic             wr_done_err,
    input logic             rd_resp_valid,
    input logic             block_defective,
    input logic             arr_we,
    input logic             arr_re,
    input logic [ARR_W-1:0] arr_wdata
);
    logic [1:0]      n_writes;
    logic            first_pend;
    logic [CW_W-1:0] first_cw;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_writes   <= '0;
            first_pend <= 1'b0;
            first_cw   <= '0;
        end else if (wr_valid && wr_ready) begin
            n_writes   <= '0;
            first_pend <= 1'b1;
        end else if (arr_we) begin
            if (n_writes != 2'd3) n_writes <= n_writes + 2'd1;
            first_pend <= 1'b0;
            if (first_pend) first_cw <= arr_wdata[CW_W-1:0];
        end
    end

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> !wr_ready);

    p_write_first_r7: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !rd_ready);

    p_err_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_done_valid && wr_done_err) |-> block_defective);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        block_defective |=> block_defective);

    p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (rst)
        !(arr_we && arr_re));

    p_two_writes_max_r9: assert property (@(posedge clk) disable iff (rst)
        n_writes <= 2'd2);

    p_single_response_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_done_valid, rd_resp_valid}));

    generate
        if (INTEGRATED) begin : g_int
            p_first_pol_zero_r2: assert property (@(posedge clk) disable iff (rst)
                (arr_we && first_pend) |-> !arr_wdata[ARR_W-1]);
            p_retry_pol_one_r3: assert property (@(posedge clk) disable iff (rst)
                (arr_we && !first_pend) |-> arr_wdata[ARR_W-1]);
        end else begin : g_unint
            p_first_pol_zero_r2: assert property (@(posedge clk) disable iff (rst)
                (arr_we && first_pend) |-> (arr_wdata[ARR_W-1 -: 3] == 3'b000));
            p_retry_inverted_r3: assert property (@(posedge clk) disable iff (rst)
                (arr_we && !first_pend) |->
                    (arr_wdata[CW_W-1:0] == ~first_cw) && (arr_wdata[ARR_W-1 -: 3] == 3'b111));
        end
    endgenerate
endmodule

bind inv_retry_ecc_ctrl invr_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INTEGRATED(INTEGRATED)
) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .wr_done_valid(wr_done_valid), .wr_done_err(wr_done_err),
    .rd_resp_valid(rd_resp_valid), .block_defective(block_defective),
    .arr_we(arr_we), .arr_re(arr_re), .arr_wdata(arr_wdata)
);

// File: tb/inv_retry_ecc_ctrl_test.sv
module invr_array_model #(
    parameter int W = 13,
    parameter int A = 4
) (
    input  logic         clk,
    input  logic         we,
    input  logic         re,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0] mem     [1<<A];
    logic [W-1:0] sa_mask [1<<A];
    logic [W-1:0] sa_val  [1<<A];

    initial begin
        rdata = '0;
        for (int i = 0; i < (1 << A); i++) begin
            mem[i] = '0; sa_mask[i] = '0; sa_val[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= (mem[addr] & ~sa_mask[addr]) | (sa_val[addr] & sa_mask[addr]);
    end
endmodule

module inv_retry_ecc_ctrl_test;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int WI = 13;
    localparam int WU = 15;
    localparam int NV = 9;
    localparam int DPOS [8] = '{2, 4, 5, 6, 8, 9, 10, 11};

    // {data, stuck mask over data bits, stuck values over data bits}
    localparam logic [23:0] VEC [NV] = '{
        {8'hA5, 8'h00, 8'h00},
        {8'h3C, 8'h01, 8'h01},
        {8'hF0, 8'h03, 8'h00},
        {8'h0F, 8'h03, 8'h00},
        {8'h55, 8'h0F, 8'h0A},
        {8'h81, 8'h07, 8'h06},
        {8'hC3, 8'h0F, 8'h01},
        {8'h96, 8'h0F, 8'h08},
        {8'h00, 8'h0F, 8'h03}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;

    logic wr_ready_i, rd_ready_i, wdv_i, wde_i, rrv_i, rrc_i, def_i, we_i, re_i;
    logic wr_ready_u, rd_ready_u, wdv_u, wde_u, rrv_u, rrc_u, def_u, we_u, re_u;
    logic [DW-1:0] rrd_i, rrd_u;
    logic [AW-1:0] aa_i, aa_u;
    logic [WI-1:0] awd_i, ard_i;
    logic [WU-1:0] awd_u, ard_u;

    inv_retry_ecc_ctrl #(.DATA_W(DW), .ADDR_W(AW), .INTEGRATED(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready_i),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_done_valid(wdv_i), .wr_done_err(wde_i),
        .rd_valid(rd_valid), .rd_ready(rd_ready_i), .rd_addr(rd_addr),
        .rd_resp_valid(rrv_i), .rd_resp_data(rrd_i), .rd_resp_corrected(rrc_i),
        .block_defective(def_i), .arr_we(we_i), .arr_re(re_i), .arr_addr(aa_i),
        .arr_wdata(awd_i), .arr_rdata(ard_i)
    );
    invr_array_model #(.W(WI), .A(AW)) mdl_i (
        .clk(clk), .we(we_i), .re(re_i), .addr(aa_i), .wdata(awd_i), .rdata(ard_i)
    );

    inv_retry_ecc_ctrl #(.DATA_W(DW), .ADDR_W(AW), .INTEGRATED(1'b0)) uut_u (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready_u),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_done_valid(wdv_u), .wr_done_err(wde_u),
        .rd_valid(rd_valid), .rd_ready(rd_ready_u), .rd_addr(rd_addr),
        .rd_resp_valid(rrv_u), .rd_resp_data(rrd_u), .rd_resp_corrected(rrc_u),
        .block_defective(def_u), .arr_we(we_u), .arr_re(re_u), .arr_addr(aa_u),
        .arr_wdata(awd_u), .arr_rdata(ard_u)
    );
    invr_array_model #(.W(WU), .A(AW)) mdl_u (
        .clk(clk), .we(we_u), .re(re_u), .addr(aa_u), .wdata(awd_u), .rdata(ard_u)
    );

    int checks = 0, failures = 0, cycles = 0;
    int nwr_i = 0, nwr_u = 0, nrd_resp = 0;
    bit done_flag = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (we_i) nwr_i++;
        if (we_u) nwr_u++;
        if (rrv_i) nrd_resp++;
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done_flag) begin
            failures++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 100000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [14:0] spread(input logic [7:0] m);
        logic [14:0] s;
        s = '0;
        for (int i = 0; i < 8; i++) s[DPOS[i]] = m[i];
        return s;
    endfunction

    function automatic int pop8(input logic [7:0] v);
        int c;
        c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        nwr_i = 0; nwr_u = 0;
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        for (int t = 0; t < 40; t++) begin
            if (wdv_i) break;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        rd_addr = a; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        for (int t = 0; t < 40; t++) begin
            if (rrv_i) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk(wr_ready_i && wr_ready_u, "R8 wr_ready after reset", int'(wr_ready_i), 1);
        chk(!def_i && !def_u, "R8 block_defective after reset", int'(def_i), 0);
        chk(!wdv_i && !rrv_i && !wdv_u && !rrv_u, "R8 no response after reset", int'(wdv_i), 0);

        // table of data patterns and stuck-at faults (R1 positions)
        for (int v = 0; v < NV; v++) begin
            logic [7:0] d, m, sv;
            int w1, w2, exp_wr, exp_corr;
            bit exp_err;
            d = VEC[v][23:16]; m = VEC[v][15:8]; sv = VEC[v][7:0];
            mdl_i.sa_mask[v] = spread(m)[WI-1:0];
            mdl_i.sa_val[v]  = spread(sv)[WI-1:0];
            mdl_u.sa_mask[v] = spread(m);
            mdl_u.sa_val[v]  = spread(sv);
            w1 = pop8(m & (sv ^ d));
            w2 = pop8(m) - w1;
            exp_err  = (w1 > 1) && (w2 > 1);
            exp_wr   = (w1 > 1) ? 2 : 1;
            exp_corr = (w1 <= 1) ? w1 : w2;

            do_write(AW'(v), d);
            chk(wdv_i && wdv_u, $sformatf("R2 done pulse vec%0d", v), int'(wdv_i), 1);
            chk(wde_i == exp_err, $sformatf("R4 integrated err vec%0d", v), int'(wde_i), int'(exp_err));
            chk(wde_u == exp_err, $sformatf("R4 unintegrated err vec%0d", v), int'(wde_u), int'(exp_err));
            chk(nwr_i == exp_wr, $sformatf("R3 integrated writes vec%0d", v), nwr_i, exp_wr);
            chk(nwr_u == exp_wr, $sformatf("R3 unintegrated writes vec%0d", v), nwr_u, exp_wr);
            if (!exp_err) begin
                do_read(AW'(v));
                chk(rrd_i == d, $sformatf("R5 integrated data vec%0d", v), int'(rrd_i), int'(d));
                chk(rrd_u == d, $sformatf("R5 unintegrated data vec%0d", v), int'(rrd_u), int'(d));
                chk(int'(rrc_i) == exp_corr, $sformatf("R5 integrated corrected vec%0d", v), int'(rrc_i), exp_corr);
                chk(int'(rrc_u) == exp_corr, $sformatf("R5 unintegrated corrected vec%0d", v), int'(rrc_u), exp_corr);
            end
        end

        // R4: defect flag set by last vector and sticky after a good write
        chk(def_i && def_u, "R4 block_defective set", int'(def_i), 1);
        do_write(4'd10, 8'h11);
        chk(!wde_i && !wde_u, "R2 clean write after defect", int'(wde_i), 0);
        chk(def_i && def_u, "R4 block_defective sticky", int'(def_u), 1);

        // R6: one polarity copy stuck wrong after an inverted retry
        mdl_u.sa_mask[12] = spread(8'h03) | 15'h2000;
        mdl_u.sa_val[12]  = 15'h0000;
        mdl_i.sa_mask[12] = spread(8'h03)[WI-1:0];
        mdl_i.sa_val[12]  = '0;
        do_write(4'd12, 8'h0F);
        chk(nwr_u == 2, "R3 retry with polarity copy fault", nwr_u, 2);
        chk(mdl_u.mem[12][14:12] == 3'b111, "R3 polarity copies written as 1", int'(mdl_u.mem[12][14:12]), 7);
        do_read(4'd12);
        chk(rrd_u == 8'h0F, "R6 majority vote keeps data", int'(rrd_u), 8'h0F);

        // R6: copy stuck at 1 while polarity is 0
        mdl_u.sa_mask[13] = 15'h4000;
        mdl_u.sa_val[13]  = 15'h4000;
        do_write(4'd13, 8'h6B);
        do_read(4'd13);
        chk(rrd_u == 8'h6B, "R6 single copy at 1 ignored", int'(rrd_u), 8'h6B);

        // R7: write wins over a simultaneous read
        @(negedge clk);
        nrd_resp = 0;
        wr_addr = 4'd14; wr_data = 8'h3A; rd_addr = 4'd14;
        wr_valid = 1'b1; rd_valid = 1'b1;
        #1;
        chk(wr_ready_i && !rd_ready_i, "R7 rd_ready low while write pending", int'(rd_ready_i), 0);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        chk(!wr_ready_i && !rd_ready_i, "R7 not ready while busy", int'(wr_ready_i), 0);
        for (int t = 0; t < 40; t++) begin
            if (wdv_i) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(nrd_resp == 0, "R7 read not taken alongside write", nrd_resp, 0);
        do_read(4'd14);
        chk(rrd_i == 8'h3A && !rrc_i, "R5 read after priority test", int'(rrd_i), 8'h3A);

        // R1: stored layout of a clean integrated write, polarity bit 12 = 0
        chk(mdl_i.mem[14][12] == 1'b0, "R1 integrated polarity index", int'(mdl_i.mem[14][12]), 0);
        chk({mdl_i.mem[14][11], mdl_i.mem[14][10], mdl_i.mem[14][9], mdl_i.mem[14][8],
             mdl_i.mem[14][6], mdl_i.mem[14][5], mdl_i.mem[14][4], mdl_i.mem[14][2]} == 8'h3A,
            "R1 integrated data positions", int'(mdl_i.mem[14]), 8'h3A);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule